// File: doc/BRIEF.md
# USB FIFO-Mode Transmit Bridge

This block moves bytes from the read side of a dual-clock FIFO into a USB bridge chip that runs a synchronous, byte-wide FIFO interface. All of its logic runs on the clock the USB chip supplies. On the FIFO side it sees a data-available flag and the head byte of a show-ahead FIFO, and it returns a one-cycle read request. On the chip side it watches an active-low transmit-ready flag and drives an active-low write strobe and the 8-bit byte bus.

The chip accepts a byte on every rising edge where both the write strobe and transmit-ready are low. Transmit-ready can rise at any point during a burst. When it rises on the same edge as a write, the chip does not take that byte. A one-entry holding slot keeps every popped byte until the chip has taken it. The byte is offered again once the chip is ready. No byte is dropped or sent twice. The block only writes, so the chip's read strobe and output-enable stay inactive.

Top module: `usb_fifo_tx_bridge`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `wr_n` is high (1) and no byte is held. `fifo_rd` stays low during reset even when `fifo_avail` is high.
- R2: `rd_n` and `oe_n` are high (1) at all times.
- R3: `wr_n` is low only in a cycle whose preceding rising edge saw `txe_n` low.
- R4: `fifo_rd` is high only while `fifo_avail` is high. Each pop loads the head byte into the holding slot, and the slot is empty or being emptied on that same edge.
- R5: A byte is refused when `wr_n` is low and `txe_n` is high on an edge. After a refusal, `wr_n` is high in the next cycle and `tx_data` still carries the refused byte.
- R6: The bytes the chip accepts (edges with `wr_n` = 0 and `txe_n` = 0) match the FIFO's pop order exactly, with no gap and no duplicate.
- R7: While `fifo_avail` and ready (`txe_n` = 0) both hold, the bridge reaches a throughput of one accepted byte per clock after a two-cycle start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the USB chip |
| rst | input | 1 | Synchronous reset, active high |
| fifo_avail | input | 1 | High when the FIFO holds at least one byte |
| fifo_q | input | 8 | Head byte of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop request; the head byte is taken on this edge |
| txe_n | input | 1 | Chip transmit-ready, active low |
| wr_n | output | 1 | Write strobe to the chip, active low |
| tx_data | output | 8 | Byte bus to the chip |
| rd_n | output | 1 | Chip read strobe, held inactive high |
| oe_n | output | 1 | Chip output enable, held inactive high |

## Verification
The assertions assume that `fifo_q` shows the true head byte whenever `fifo_avail` is high. They also assume that `fifo_avail` never claims data the FIFO does not hold, and that `txe_n` changes only between clock edges. The bench meets these assumptions with a FIFO model built from a produced count and a next-index pointer. The pointer cannot pass the count, and the head byte is the low byte of the pointer. The model and `txe_n` are updated on the falling edge, and the refusal pattern comes from seeded random draws, mixed with directed phases: a long ready run, a toggle on every cycle, and a sparse FIFO.

// File: rtl/usbw_pkg.sv
package usbw_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } slot_t;

    // The chip takes a byte on an edge where both strobes are low
    function automatic logic chip_takes(input logic wr_n, input logic txe_n);
        return !wr_n && !txe_n;
    endfunction
endpackage

// File: rtl/usbw_slot.sv
module usbw_slot #(
    parameter int W = usbw_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         avail,
    input  logic [W-1:0] head,
    input  logic         taken,
    output logic         pop,
    output logic         vld,
    output logic         vld_next,
    output logic [W-1:0] dat
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign pop      = !rst && avail && (!vld_q || taken);
    assign vld_next = pop || (vld_q && !taken);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_next;
            if (pop)
                dat_q <= head;
        end
    end

    assign vld = vld_q;
    assign dat = dat_q;
endmodule

// File: rtl/usbw_strobe.sv
module usbw_strobe (
    input  logic clk,
    input  logic rst,
    input  logic vld_next,
    input  logic txe_n,
    output logic wr_n
);
    logic wr_n_q;

    always_ff @(posedge clk) begin
        if (rst)
            wr_n_q <= 1'b1;
        else
            wr_n_q <= !(vld_next && !txe_n);
    end

    assign wr_n = wr_n_q;
endmodule

// File: rtl/usb_fifo_tx_bridge.sv
module usb_fifo_tx_bridge #(
    parameter int BYTE_W = usbw_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_avail,
    input  logic [BYTE_W-1:0] fifo_q,
    output logic              fifo_rd,
    input  logic              txe_n,
    output logic              wr_n,
    output logic [BYTE_W-1:0] tx_data,
    output logic              rd_n,
    output logic              oe_n
);
    import usbw_pkg::*;

    logic taken;
    logic slot_vld;
    logic slot_vld_next;
    logic [BYTE_W-1:0] slot_dat;

    assign taken = chip_takes(wr_n, txe_n);

    usbw_slot #(.W(BYTE_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .avail    (fifo_avail),
        .head     (fifo_q),
        .taken    (taken),
        .pop      (fifo_rd),
        .vld      (slot_vld),
        .vld_next (slot_vld_next),
        .dat      (slot_dat)
    );

    usbw_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .vld_next (slot_vld_next),
        .txe_n    (txe_n),
        .wr_n     (wr_n)
    );

    assign tx_data = slot_dat;
    assign rd_n    = 1'b1;
    assign oe_n    = 1'b1;
endmodule

// File: rtl/usbw_checker.sv
module usbw_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         txe_n,
    input logic         wr_n,
    input logic [W-1:0] tx_data,
    input logic         fifo_rd,
    input logic         fifo_avail,
    input logic [W-1:0] fifo_q,
    input logic         slot_vld,
    input logic         rd_n,
    input logic         oe_n
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_n && !slot_vld));

    // R2
    idle_strobes_chk: assert property (@(posedge clk) rd_n && oe_n);

    // R3
    strobe_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> $past(!txe_n));

    // R4
    pop_avail_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> fifo_avail);

    // R4
    pop_lands_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> (slot_vld && tx_data == $past(fifo_q)));

    // R5
    refused_held_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && txe_n) |=> (wr_n && slot_vld && $stable(tx_data)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_vld && !(!wr_n && !txe_n)) |=> (slot_vld && $stable(tx_data)));
endmodule

bind usb_fifo_tx_bridge usbw_checker #(.W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txe_n      (txe_n),
    .wr_n       (wr_n),
    .tx_data    (tx_data),
    .fifo_rd    (fifo_rd),
    .fifo_avail (fifo_avail),
    .fifo_q     (fifo_q),
    .slot_vld   (slot_vld),
    .rd_n       (rd_n),
    .oe_n       (oe_n)
);

// File: tb/tb_usb_fifo_tx_bridge.sv
`timescale 1ns/1ps
module tb_usb_fifo_tx_bridge;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_avail;
    logic [7:0] fifo_q;
    logic       fifo_rd;
    logic       txe_n;
    logic       wr_n;
    logic [7:0] tx_data;
    logic       rd_n;
    logic       oe_n;

    int checks = 0;
    int fails  = 0;
    int produced = 0;
    int nxt = 0;
    int expn = 0;
    int acc = 0;
    int seed = 1234;
    logic       prev_txe = 1'b1;
    logic       prev_refused = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic       done = 1'b0;

    localparam int TOTAL = 3000;

    usb_fifo_tx_bridge dut (
        .clk(clk), .rst(rst), .fifo_avail(fifo_avail), .fifo_q(fifo_q),
        .fifo_rd(fifo_rd), .txe_n(txe_n), .wr_n(wr_n), .tx_data(tx_data),
        .rd_n(rd_n), .oe_n(oe_n)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pattern(input int idx);
        return idx[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive on the falling edge, then predict the next rising edge
    task automatic step(input logic txe_val, input int add);
        @(negedge clk);
        if (prev_refused) begin
            check(wr_n == 1'b1, "R5 strobe", wr_n, 1);
            check(tx_data == prev_data, "R5 data", tx_data, prev_data);
        end
        if (!wr_n) check(prev_txe == 1'b0, "R3", prev_txe, 0);
        check(rd_n && oe_n, "R2", {rd_n, oe_n}, 3);
        produced = produced + add;
        if (produced > TOTAL) produced = TOTAL;
        txe_n      = txe_val;
        fifo_avail = (nxt < produced);
        fifo_q     = pattern(nxt);
        #1;
        if (fifo_rd) begin
            check(fifo_avail == 1'b1, "R4", fifo_avail, 1);
            nxt++;
        end
        if (!wr_n && !txe_n) begin
            check(tx_data == pattern(expn), "R6", tx_data, pattern(expn));
            expn++;
            acc++;
        end
        prev_refused = !wr_n && txe_n;
        prev_data    = tx_data;
        prev_txe     = txe_n;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed));
        rst = 1'b1;
        txe_n = 1'b0;
        fifo_avail = 1'b1;
        fifo_q = 8'hA5;
        repeat (3) @(negedge clk);
        #1;
        // R1: idle strobe and no pop while reset is held with data waiting
        check(wr_n == 1'b1, "R1 wr_n", wr_n, 1);
        check(fifo_rd == 1'b0, "R1 fifo_rd", fifo_rd, 0);
        check(rd_n && oe_n, "R2 reset", {rd_n, oe_n}, 3);
        fifo_avail = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(wr_n == 1'b1, "R1 after", wr_n, 1);

        // R7: long ready run with a full FIFO
        produced = 200;
        acc = 0;
        for (int i = 0; i < 100; i++) step(1'b0, 0);
        check(acc >= 98, "R7 rate", acc, 98);

        // toggling ready on every cycle
        for (int i = 0; i < 200; i++) step(i[0], 1);

        // random refusals during bursts, FIFO fed fast
        for (int i = 0; i < 1500; i++)
            step(($urandom % 10) < 3, ($urandom % 4 != 0) ? 1 : 0);

        // sparse FIFO, mostly ready
        for (int i = 0; i < 1500; i++)
            step(($urandom % 10) < 1, ($urandom % 5 == 0) ? 1 : 0);

        // drain everything
        produced = TOTAL;
        for (int i = 0; i < 6000 && expn < TOTAL; i++)
            step(($urandom % 10) < 2, 0);
        check(expn == TOTAL, "R6 count", expn, TOTAL);
        check(nxt == TOTAL, "R4 pops", nxt, TOTAL);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule